// File: doc/BRIEF.md
# Unprivileged Load Execute Unit

This block runs one "load as user" instruction. It is handed an instruction word that has already been fetched, a flag that says whether the word uses the 32-bit encoding family or the 16+16-bit family, the hypervisor-level indication, the carry flag and the outcome of the external condition check. It decodes the three encoding forms and reads the base and index registers through two read ports. It then forms the offset, the access address and the value to write back.

On a legal, condition-passing instruction the unit issues one 4-byte read over a valid/ready request channel. The read is marked so that permission checks treat it as coming from user mode. The unit then waits for a response carrying data and an error bit, and finally writes the loaded word to the destination register and, for the post-indexed forms, the new base to the base register.

Words that are not this instruction, illegal register choices and failed conditions all end in a one-cycle `done` pulse with no side effects. Words that are not this instruction also raise `not_mine`, and illegal register choices also raise `undef`.

Top module: `user_load_exec`

## Requirements
- R1: With `thumb`=0, bits[27:24]=0100, bits[22:20]=011 and bits[31:28]≠1111, the word is the immediate form: base index in [19:16], destination in [15:12], zero-extended 12-bit offset in [11:0]. The read address is the unmodified base, the destination receives the loaded word and the base receives base±offset.
- R2: With `thumb`=0, bits[27:24]=0110, bits[22:20]=011, bit[4]=0 and bits[31:28]≠1111, the word is the register form: index register in [3:0], shift amount in [11:7], shift kind in [6:5], otherwise as R1. The offset is the shifted index register.
- R3: Shift kind 00 shifts left by the amount. Kind 01 is a logical right shift and kind 10 an arithmetic right shift, with amount 0 meaning 32 for both. Kind 11 with amount 0 gives {carry, value[31:1]}; with any other amount it is a rotate right.
- R4: Bit[23] of a 32-bit form picks the sign: 1 adds the offset to the base, 0 subtracts it.
- R5: With `thumb`=1, bits[31:20]=111110000101 and bits[11:8]=1110, the base index is in [19:16], the destination in [15:12] and an 8-bit offset in [7:0]. The read address is base+offset, and the base register is not written.
- R6: A word matching none of these forms, a 32-bit word with bits[31:28]=1111, or a 16+16-bit word with base index 1111, raises `not_mine` together with `done`. It issues no read and makes no register write.
- R7: A destination of 15, or a base of 15, or an index register of 15 in the register form, or a base equal to the destination in the 32-bit forms, raises `undef` together with `done`. It issues no read and makes no register write.
- R8: The request's `mem_req_unpriv` is 1, except when `at_hyp` was 1 at start; then the read is issued with `mem_req_unpriv`=0.
- R9: When `cond_pass` is 0 at start, a recognised instruction ends with `done` alone: no read, no register write, no `undef`.
- R10: Once `mem_req_valid` rises it stays high, with address and tag unchanged, until a cycle in which `mem_req_ready` is 1.
- R11: A response with `mem_rsp_err`=1 raises `abort` with `done` and writes no register.
- R12: A good response produces, one cycle after it is accepted, a single cycle in which `done`, the destination write and (post-indexed forms only) the base write are all asserted.
- R13: After reset `done`, `undef`, `abort`, `not_mine`, `mem_req_valid` and both write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept the instruction on the inputs below (when idle) |
| instr | input | 32 | Instruction word |
| thumb | input | 1 | 1 = 16+16-bit family, 0 = 32-bit family |
| at_hyp | input | 1 | Executing at the hypervisor level |
| carry_in | input | 1 | Current carry flag |
| cond_pass | input | 1 | External condition check result |
| busy | output | 1 | Instruction in progress |
| rd_n_idx | output | 4 | Base register read index |
| rd_n_data | input | DW | Base register value (combinational read) |
| rd_m_idx | output | 4 | Index register read index |
| rd_m_data | input | DW | Index register value (combinational read) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | DW | Byte address of the 4-byte read |
| mem_req_unpriv | output | 1 | Read is checked as user mode |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | DW | Loaded word |
| mem_rsp_err | input | 1 | Response reports a fault |
| wr_t_en | output | 1 | Destination write enable |
| wr_t_idx | output | 4 | Destination index |
| wr_t_data | output | DW | Destination data |
| wr_n_en | output | 1 | Base write enable |
| wr_n_idx | output | 4 | Base index |
| wr_n_data | output | DW | New base value |
| done | output | 1 | Instruction finished (one cycle) |
| undef | output | 1 | Illegal register combination |
| abort | output | 1 | Read returned an error |
| not_mine | output | 1 | Word is not this instruction |

## Verification
A wrong latched decode shows at the ports within two cycles of `start`, either as a wrong read index or address on the request or as an early `done` with the wrong flag. A wrong shift or sign selection stays hidden until the base write. That write appears in the same cycle as `done`, one cycle after the response, so the new-base value is compared for every post-indexed case. A state machine stuck in the request or response state shows as a missing `done`, which the scoreboard reports when its queue never drains.

// File: rtl/ulx_pkg.sv
package ulx_pkg;
  localparam int RW = 4;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHK,
    ST_REQ,
    ST_RSP
  } ldu_state_e;

  typedef struct packed {
    logic          mine;
    logic          illegal;
    logic          reg_form;
    logic          post;
    logic          add;
    logic [RW-1:0] rn;
    logic [RW-1:0] rt;
    logic [RW-1:0] rm;
    logic [11:0]   imm;
    shift_kind_e   sk;
    logic [4:0]    samt;
  } ldu_dec_t;
endpackage

// File: rtl/ulx_decode.sv
module ulx_decode
  import ulx_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        thumb,
  output ldu_dec_t    dec
);
  localparam logic [RW-1:0] PC_IDX = '1;

  logic is_imm, is_reg;

  always_comb begin
    dec    = '0;
    is_imm = 1'b0;
    is_reg = 1'b0;
    if (!thumb) begin
      is_imm       = (instr[27:24] == 4'b0100) && (instr[22:20] == 3'b011);
      is_reg       = (instr[27:24] == 4'b0110) && (instr[22:20] == 3'b011) && !instr[4];
      dec.mine     = (is_imm || is_reg) && (instr[31:28] != 4'hF);
      dec.reg_form = is_reg;
      dec.post     = 1'b1;
      dec.add      = instr[23];
      dec.rn       = instr[19:16];
      dec.rt       = instr[15:12];
      dec.rm       = instr[3:0];
      dec.imm      = instr[11:0];
      dec.sk       = shift_kind_e'(instr[6:5]);
      dec.samt     = instr[11:7];
      dec.illegal  = (dec.rt == PC_IDX) || (dec.rn == PC_IDX) ||
                     (dec.rn == dec.rt) || (is_reg && dec.rm == PC_IDX);
    end else begin
      dec.mine     = (instr[31:20] == 12'hF85) && (instr[19:16] != 4'hF) &&
                     (instr[11:8] == 4'hE);
      dec.reg_form = 1'b0;
      dec.post     = 1'b0;
      dec.add      = 1'b1;
      dec.rn       = instr[19:16];
      dec.rt       = instr[15:12];
      dec.imm      = {4'b0000, instr[7:0]};
      dec.illegal  = (dec.rt == PC_IDX);
    end
  end
endmodule

// File: rtl/ulx_shift.sv
module ulx_shift
  import ulx_pkg::*;
#(
  parameter int W = 32,
  localparam int AMW = $clog2(W)
) (
  input  logic [W-1:0]   val,
  input  shift_kind_e    kind,
  input  logic [AMW-1:0] amt,
  input  logic           cin,
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (kind)
      SH_LSL: res = val << amt;
      SH_LSR: res = (amt == '0) ? '0 : (val >> amt);
      SH_ASR: res = (amt == '0) ? {W{val[W-1]}} : W'($signed(val) >>> amt);
      default: begin
        if (amt == '0) res = {cin, val[W-1:1]};
        else           res = (val >> amt) | (val << (W - int'(amt)));
      end
    endcase
  end
endmodule

// File: rtl/ulx_agu.sv
module ulx_agu #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] off,
  input  logic         add,
  input  logic         post,
  output logic [W-1:0] addr,
  output logic [W-1:0] wb
);
  logic [W-1:0] sum;

  always_comb begin
    sum  = add ? (base + off) : (base - off);
    addr = post ? base : sum;
    wb   = sum;
  end
endmodule

// File: rtl/user_load_exec.sv
module user_load_exec
  import ulx_pkg::*;
#(
  parameter int DW = 32,
  localparam int AMW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic          thumb,
  input  logic          at_hyp,
  input  logic          carry_in,
  input  logic          cond_pass,
  output logic          busy,
  output logic [RW-1:0] rd_n_idx,
  input  logic [DW-1:0] rd_n_data,
  output logic [RW-1:0] rd_m_idx,
  input  logic [DW-1:0] rd_m_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [DW-1:0] mem_req_addr,
  output logic          mem_req_unpriv,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          wr_t_en,
  output logic [RW-1:0] wr_t_idx,
  output logic [DW-1:0] wr_t_data,
  output logic          wr_n_en,
  output logic [RW-1:0] wr_n_idx,
  output logic [DW-1:0] wr_n_data,
  output logic          done,
  output logic          undef,
  output logic          abort,
  output logic          not_mine
);
  ldu_state_e   state_q;
  ldu_dec_t     dec_d, dec_q;
  logic         hyp_q, carry_q, cpass_q;
  logic [DW-1:0] wb_q;
  logic [DW-1:0] shifted, offset, agu_addr, agu_wb;

  ulx_decode u_dec (
    .instr (instr),
    .thumb (thumb),
    .dec   (dec_d)
  );

  ulx_shift #(.W(DW)) u_shf (
    .val  (rd_m_data),
    .kind (dec_q.sk),
    .amt  (AMW'(dec_q.samt)),
    .cin  (carry_q),
    .res  (shifted)
  );

  assign offset = dec_q.reg_form ? shifted : {{(DW-12){1'b0}}, dec_q.imm};

  ulx_agu #(.W(DW)) u_agu (
    .base (rd_n_data),
    .off  (offset),
    .add  (dec_q.add),
    .post (dec_q.post),
    .addr (agu_addr),
    .wb   (agu_wb)
  );

  assign rd_n_idx = dec_q.rn;
  assign rd_m_idx = dec_q.rm;
  assign busy     = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      dec_q          <= '0;
      hyp_q          <= 1'b0;
      carry_q        <= 1'b0;
      cpass_q        <= 1'b0;
      wb_q           <= '0;
      mem_req_valid  <= 1'b0;
      mem_req_addr   <= '0;
      mem_req_unpriv <= 1'b0;
      wr_t_en        <= 1'b0;
      wr_t_idx       <= '0;
      wr_t_data      <= '0;
      wr_n_en        <= 1'b0;
      wr_n_idx       <= '0;
      wr_n_data      <= '0;
      done           <= 1'b0;
      undef          <= 1'b0;
      abort          <= 1'b0;
      not_mine       <= 1'b0;
    end else begin
      done     <= 1'b0;
      undef    <= 1'b0;
      abort    <= 1'b0;
      not_mine <= 1'b0;
      wr_t_en  <= 1'b0;
      wr_n_en  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            dec_q   <= dec_d;
            hyp_q   <= at_hyp;
            carry_q <= carry_in;
            cpass_q <= cond_pass;
            state_q <= ST_CHK;
          end
        end
        ST_CHK: begin
          if (!dec_q.mine) begin
            not_mine <= 1'b1;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (!cpass_q) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (dec_q.illegal) begin
            undef   <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            mem_req_valid  <= 1'b1;
            mem_req_addr   <= agu_addr;
            mem_req_unpriv <= !hyp_q;
            wb_q           <= agu_wb;
            state_q        <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state_q       <= ST_RSP;
          end
        end
        default: begin
          if (mem_rsp_valid) begin
            done    <= 1'b1;
            state_q <= ST_IDLE;
            if (mem_rsp_err) begin
              abort <= 1'b1;
            end else begin
              wr_t_en   <= 1'b1;
              wr_t_idx  <= dec_q.rt;
              wr_t_data <= mem_rsp_data;
              wr_n_en   <= dec_q.post;
              wr_n_idx  <= dec_q.rn;
              wr_n_data <= wb_q;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ulx_chk.sv
module ulx_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [DW-1:0] mem_req_addr,
  input logic          mem_req_unpriv,
  input logic          wr_t_en,
  input logic          wr_n_en,
  input logic          done,
  input logic          undef,
  input logic          abort,
  input logic          not_mine
);
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_unpriv));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  wr_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_t_en || wr_n_en) |-> done);

  // R12
  wb_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wr_n_en |-> wr_t_en);

  // R7
  undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    undef |-> !wr_t_en && !wr_n_en && !mem_req_valid);

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> !wr_t_en && !wr_n_en);

  // R6
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({undef, abort, not_mine, wr_t_en}));

  // R13
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done && !mem_req_valid && !wr_t_en && !wr_n_en);
endmodule

bind user_load_exec ulx_chk #(.DW(DW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_addr   (mem_req_addr),
  .mem_req_unpriv (mem_req_unpriv),
  .wr_t_en        (wr_t_en),
  .wr_n_en        (wr_n_en),
  .done           (done),
  .undef          (undef),
  .abort          (abort),
  .not_mine       (not_mine)
);

// File: tb/tb_user_load_exec.sv
`timescale 1ns/1ps
module tb_user_load_exec;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 0, thumb = 0, at_hyp = 0, carry_in = 0, cond_pass = 1;
  logic [31:0] instr = '0;
  logic        busy;
  logic [3:0]  rd_n_idx, rd_m_idx;
  logic [31:0] rd_n_data, rd_m_data;
  logic        mem_req_valid, mem_req_unpriv;
  logic        mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        wr_t_en, wr_n_en, done, undef, abort, not_mine;
  logic [3:0]  wr_t_idx, wr_n_idx;
  logic [31:0] wr_t_data, wr_n_data;

  user_load_exec #(.DW(DW)) dut (.*);

  function automatic logic [31:0] rv(input logic [3:0] i);
    case (i)
      4'd7:    return 32'h0000_0011;
      4'd9:    return 32'h8000_0010;
      4'd11:   return 32'hF000_000F;
      default: return 32'h1000_0000 + (32'(i) << 8);
    endcase
  endfunction

  assign rd_n_data = rv(rd_n_idx);
  assign rd_m_data = rv(rd_m_idx);

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return a ^ 32'h5A5A_F00F;
  endfunction

  function automatic logic [31:0] bsh(input logic [31:0] v, input logic [1:0] t,
                                      input int a, input logic c);
    logic [31:0] r;
    r = v;
    case (t)
      2'b00: r = v << a;
      2'b01: r = (a == 0) ? 32'h0 : v >> a;
      2'b10: for (int i = 0; i < ((a == 0) ? 32 : a); i++) r = {r[31], r[31:1]};
      default: begin
        if (a == 0) r = {c, v[31:1]};
        else for (int i = 0; i < a; i++) r = {r[0], r[31:1]};
      end
    endcase
    return r;
  endfunction

  function automatic logic [31:0] a_imm(input logic u, input logic [3:0] rn, rt,
                                        input logic [11:0] imm, input logic [3:0] cc);
    return {cc, 4'b0100, u, 3'b011, rn, rt, imm};
  endfunction

  function automatic logic [31:0] a_reg(input logic u, input logic [3:0] rn, rt,
                                        input logic [4:0] sa, input logic [1:0] ty,
                                        input logic [3:0] rm);
    return {4'hE, 4'b0110, u, 3'b011, rn, rt, sa, ty, 1'b0, rm};
  endfunction

  function automatic logic [31:0] t_imm(input logic [3:0] rn, rt, input logic [7:0] imm);
    return {12'hF85, rn, rt, 4'hE, imm};
  endfunction

  typedef struct {
    bit          req;
    logic [31:0] addr;
    bit          unpriv;
    bit          wt;
    logic [3:0]  ti;
    logic [31:0] td;
    bit          wn;
    logic [3:0]  ni;
    logic [31:0] nd;
    bit          und;
    bit          abt;
    bit          nm;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0;
  bit   finished = 0;

  bit          rsp_err_tb = 0;
  int          rdy_wait = 0, wcnt = 0;
  bit          rsp_pend = 0, cap_req = 0, cap_unpriv = 0;
  logic [31:0] cap_addr = '0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t e_post(input string tag, input logic [3:0] rn, rt,
                                  input logic [31:0] off, input bit add, input bit up);
    exp_t e;
    e = '{default: 0, tag: tag};
    e.req = 1; e.addr = rv(rn); e.unpriv = up;
    e.wt = 1; e.ti = rt; e.td = mdata(rv(rn));
    e.wn = 1; e.ni = rn; e.nd = add ? rv(rn) + off : rv(rn) - off;
    return e;
  endfunction

  function automatic exp_t e_thumb(input string tag, input logic [3:0] rn, rt,
                                   input logic [31:0] off, input bit up);
    exp_t e;
    e = '{default: 0, tag: tag};
    e.req = 1; e.addr = rv(rn) + off; e.unpriv = up;
    e.wt = 1; e.ti = rt; e.td = mdata(rv(rn) + off);
    return e;
  endfunction

  function automatic exp_t e_quiet(input string tag, input bit und, input bit nm);
    exp_t e;
    e = '{default: 0, tag: tag};
    e.und = und; e.nm = nm;
    return e;
  endfunction

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (q.size() == 0) begin
          chk("R12", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, "request issued", 32'(cap_req), 32'(e.req));
          if (e.req) begin
            chk(e.tag, "request address", cap_addr, e.addr);
            chk(e.tag, "request unpriv tag", 32'(cap_unpriv), 32'(e.unpriv));
          end
          chk(e.tag, "dest write enable", 32'(wr_t_en), 32'(e.wt));
          if (e.wt) begin
            chk(e.tag, "dest index", 32'(wr_t_idx), 32'(e.ti));
            chk(e.tag, "dest data", wr_t_data, e.td);
          end
          chk(e.tag, "base write enable", 32'(wr_n_en), 32'(e.wn));
          if (e.wn) begin
            chk(e.tag, "base index", 32'(wr_n_idx), 32'(e.ni));
            chk(e.tag, "base data", wr_n_data, e.nd);
          end
          chk(e.tag, "undef", 32'(undef), 32'(e.und));
          chk(e.tag, "abort", 32'(abort), 32'(e.abt));
          chk(e.tag, "not_mine", 32'(not_mine), 32'(e.nm));
          cap_req = 0;
        end
      end
      if (rsp_pend) begin
        mem_rsp_valid = 1;
        mem_rsp_data  = mdata(cap_addr);
        mem_rsp_err   = rsp_err_tb;
        rsp_pend      = 0;
      end else begin
        mem_rsp_valid = 0;
      end
      mem_req_ready = 0;
      if (mem_req_valid) begin
        if (wcnt >= rdy_wait) begin
          mem_req_ready = 1;
          cap_req    = 1;
          cap_addr   = mem_req_addr;
          cap_unpriv = mem_req_unpriv;
          rsp_pend   = 1;
          wcnt       = 0;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic issue(input logic [31:0] w, input bit th, hy, cy, cp, er,
                       input int rw, input exp_t e);
    rsp_err_tb = er;
    rdy_wait   = rw;
    q.push_back(e);
    @(negedge clk);
    instr = w; thumb = th; at_hyp = hy; carry_in = cy; cond_pass = cp;
    start = 1;
    @(negedge clk);
    start = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
  end

  initial begin
    exp_t e;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R13: quiet outputs after reset
    chk("R13", "done", 32'(done), 0);
    chk("R13", "req valid", 32'(mem_req_valid), 0);
    chk("R13", "writes", 32'(wr_t_en | wr_n_en), 0);
    chk("R13", "flags", 32'(undef | abort | not_mine), 0);

    // R1 immediate form, adding
    issue(a_imm(1, 4'd2, 4'd3, 12'h123, 4'hE), 0, 0, 0, 1, 0, 0,
          e_post("R1", 4'd2, 4'd3, 32'h123, 1, 1));
    // R4 subtracting, largest offset
    issue(a_imm(0, 4'd4, 4'd5, 12'hFFF, 4'h0), 0, 0, 0, 1, 0, 1,
          e_post("R4", 4'd4, 4'd5, 32'hFFF, 0, 1));
    // R2 / R3 register form, LSL 3
    issue(a_reg(1, 4'd1, 4'd6, 5'd3, 2'b00, 4'd7), 0, 0, 0, 1, 0, 0,
          e_post("R2", 4'd1, 4'd6, bsh(rv(4'd7), 2'b00, 3, 0), 1, 1));
    // R3 LSR amount 0 means 32
    issue(a_reg(1, 4'd1, 4'd6, 5'd0, 2'b01, 4'd9), 0, 0, 0, 1, 0, 0,
          e_post("R3", 4'd1, 4'd6, bsh(rv(4'd9), 2'b01, 0, 0), 1, 1));
    // R3 ASR amount 0 means 32 on a negative value
    issue(a_reg(1, 4'd2, 4'd6, 5'd0, 2'b10, 4'd9), 0, 0, 0, 1, 0, 0,
          e_post("R3", 4'd2, 4'd6, bsh(rv(4'd9), 2'b10, 0, 0), 1, 1));
    // R3 rotate right 4, subtracting
    issue(a_reg(0, 4'd3, 4'd6, 5'd4, 2'b11, 4'd11), 0, 0, 0, 1, 0, 0,
          e_post("R3", 4'd3, 4'd6, bsh(rv(4'd11), 2'b11, 4, 0), 0, 1));
    // R3 rotate through carry
    issue(a_reg(1, 4'd4, 4'd6, 5'd0, 2'b11, 4'd7), 0, 0, 1, 1, 0, 0,
          e_post("R3", 4'd4, 4'd6, bsh(rv(4'd7), 2'b11, 0, 1), 1, 1));
    // R5 16+16 form
    issue(t_imm(4'd8, 4'd10, 8'h40), 1, 0, 0, 1, 0, 0,
          e_thumb("R5", 4'd8, 4'd10, 32'h40, 1));
    // R8 hypervisor level: untagged read
    issue(t_imm(4'd8, 4'd10, 8'hFF), 1, 1, 0, 1, 0, 0,
          e_thumb("R8", 4'd8, 4'd10, 32'hFF, 0));
    issue(a_imm(1, 4'd2, 4'd3, 12'h010, 4'hE), 0, 1, 0, 1, 0, 0,
          e_post("R8", 4'd2, 4'd3, 32'h10, 1, 0));
    // R6 not this instruction
    issue(t_imm(4'd15, 4'd10, 8'h00), 1, 0, 0, 1, 0, 0, e_quiet("R6", 0, 1));
    issue(a_imm(1, 4'd2, 4'd3, 12'h004, 4'hF), 0, 0, 0, 1, 0, 0, e_quiet("R6", 0, 1));
    issue(a_reg(1, 4'd1, 4'd6, 5'd0, 2'b00, 4'd7) | 32'h10, 0, 0, 0, 1, 0, 0,
          e_quiet("R6", 0, 1));
    // R7 illegal registers
    issue(a_imm(1, 4'd5, 4'd5, 12'h004, 4'hE), 0, 0, 0, 1, 0, 0, e_quiet("R7", 1, 0));
    issue(a_reg(1, 4'd1, 4'd6, 5'd0, 2'b00, 4'd15), 0, 0, 0, 1, 0, 0, e_quiet("R7", 1, 0));
    issue(t_imm(4'd8, 4'd15, 8'h04), 1, 0, 0, 1, 0, 0, e_quiet("R7", 1, 0));
    issue(a_imm(1, 4'd15, 4'd3, 12'h004, 4'hE), 0, 0, 0, 1, 0, 0, e_quiet("R7", 1, 0));
    // R9 condition failed
    issue(a_imm(1, 4'd2, 4'd3, 12'h008, 4'hE), 0, 0, 0, 0, 0, 0, e_quiet("R9", 0, 0));
    // R11 error response
    e = e_post("R11", 4'd2, 4'd3, 32'h20, 1, 1);
    e.wt = 0; e.wn = 0; e.abt = 1;
    issue(a_imm(1, 4'd2, 4'd3, 12'h020, 4'hE), 0, 0, 0, 1, 1, 0, e);
    // R10 slow ready; R12 writes afterwards
    issue(a_reg(0, 4'd12, 4'd1, 5'd2, 2'b00, 4'd7), 0, 0, 0, 1, 0, 3,
          e_post("R10", 4'd12, 4'd1, bsh(rv(4'd7), 2'b00, 2, 0), 0, 1));
    issue(a_imm(1, 4'd2, 4'd3, 12'h000, 4'hE), 0, 0, 0, 1, 0, 0,
          e_post("R12", 4'd2, 4'd3, 32'h0, 1, 1));
    repeat (3) @(negedge clk);
    summary();
  end
endmodule